// File: doc/BRIEF.md
# Monochrome STN Panel Refresh Engine

This block keeps a monochrome STN graphic panel refreshed from an on-chip frame buffer. A host writes and reads the buffer through a plain address, data and write-enable port with one cycle of read latency. Independently, a scan engine reads the buffer line by line and sends it to the panel as four-pixel nibbles. It drives a shift clock, a line latch strobe and a first-line marker alongside the nibbles.

Everything runs on one system clock at eight times the transfer rate. A free-running 3-bit phase counter cuts time into 8-cycle slots. One-cycle enables decoded from it start the buffer read, load the data outputs and move the shift clock, so no divided clock drives any logic. Each row is `COLS/4` data slots followed by one latch slot. A frame is `ROWS` such rows. Panel geometry is set by parameters.

Top module: `stn_scan`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the phase, column and row counters are zero and `pnl_data`, `pnl_shclk`, `pnl_latch` and `pnl_frame` are all low. This also holds when reset is applied in the middle of a scan.
- R2: A host write stores `hst_wdata` at `hst_addr` on the clock edge where `hst_we` is high. `hst_rdata` shows the word at the address presented at the previous edge. A read and a write at the same edge return the old content.
- R3: Count cycles from the release of reset, starting at 0, and take phase = count mod 8. In every data slot, `pnl_shclk` is high in exactly the cycles of phases 1 to 4 and low in phases 5 to 0, giving a 50% square wave of period 8.
- R4: Each row is `COLS/4` data slots followed by one latch slot. `pnl_latch` is high for all 8 cycles of the latch slot and low otherwise. `pnl_shclk` stays low throughout the latch slot.
- R5: A data slot for row r and column c fetches the buffer word at address r*(COLS/4)+c. Its bits [3:0] appear on `pnl_data` from phase 4 of that slot through phase 3 of the next slot. A latch slot loads 0 in the same way.
- R6: The row advances only when a latch slot ends, and wraps to 0 after row `ROWS`-1. The whole output pattern therefore repeats every (COLS/4+1)*ROWS slots.
- R7: `pnl_frame` is high during exactly the latch slot that ends row `ROWS`-1, and low at all other times.
- R8: The block runs correctly at the smallest legal geometry, `COLS`=8 and `ROWS`=2: latch slots fall at slots 2 and 5 of each 6-slot frame, and the frame marker at slot 5. Elaboration stops when `COLS` is not a multiple of 4, is below 8, or `ROWS` is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, eight times the transfer rate |
| rst | input | 1 | Synchronous reset, active high |
| hst_addr | input | AW | Host word address |
| hst_wdata | input | 4 | Host write data |
| hst_we | input | 1 | Host write enable |
| hst_rdata | output | 4 | Host read data, one cycle after the address |
| pnl_data | output | 4 | Four-pixel nibble to the panel |
| pnl_shclk | output | 1 | Panel shift clock |
| pnl_latch | output | 1 | Line latch strobe, one slot wide |
| pnl_frame | output | 1 | First-line marker |

## Verification
The panel outputs are registered, so a value decoded from phase p becomes visible in the cycle of phase p+1. The shift clock is set at phase 0 and seen at phases 1 to 4. A nibble is read at phase 1, loaded at phase 3 and seen from phase 4. Latch and frame change at the slot boundary. The bench counts cycles from reset release and samples every output on the falling edge of each cycle. It compares each sample to a slot and phase model built from the requirements. Host reads are checked one edge after the address is presented, including a read at the same edge as a write.

// File: rtl/stn_scan.sv
module stn_scan #(
  parameter int COLS = 16,
  parameter int ROWS = 4,
  parameter int AW   = $clog2((COLS / 4) * ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] hst_addr,
  input  logic [3:0]    hst_wdata,
  input  logic          hst_we,
  output logic [3:0]    hst_rdata,
  output logic [3:0]    pnl_data,
  output logic          pnl_shclk,
  output logic          pnl_latch,
  output logic          pnl_frame
);

  localparam int WPR   = COLS / 4;
  localparam int DEPTH = WPR * ROWS;
  localparam int HW    = $clog2(WPR);
  localparam int VW    = $clog2(ROWS);

  generate
    if ((COLS % 4) != 0 || COLS < 8 || ROWS < 2) begin : g_bad_geometry
      $error("stn_scan: COLS must be a multiple of 4 and >= 8, ROWS >= 2");
    end
  endgenerate

  logic [3:0]    mem [DEPTH];
  logic [2:0]    ph;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          lslot;
  logic [3:0]    rd_q;
  logic [3:0]    dat_q;
  logic          shclk_q;
  logic [AW-1:0] scan_addr;

  wire slot_end = (ph == 3'd7);
  wire h_last   = (hcnt == HW'(WPR - 1));
  wire v_last   = (vcnt == VW'(ROWS - 1));

  assign scan_addr = AW'(vcnt) * AW'(WPR) + AW'(hcnt);

  always_ff @(posedge clk) begin
    if (hst_we) mem[hst_addr] <= hst_wdata;
    hst_rdata <= mem[hst_addr];
  end

  always_ff @(posedge clk) begin
    if (ph == 3'd1) rd_q <= mem[scan_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
      lslot <= 1'b0;
    end else begin
      ph <= ph + 3'd1;
      if (slot_end) begin
        if (lslot) begin
          lslot <= 1'b0;
          hcnt  <= '0;
          vcnt  <= v_last ? '0 : vcnt + VW'(1);
        end else if (h_last) begin
          lslot <= 1'b1;
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shclk_q <= 1'b0;
      dat_q   <= '0;
    end else begin
      if (ph == 3'd0)      shclk_q <= ~lslot;
      else if (ph == 3'd4) shclk_q <= 1'b0;
      if (ph == 3'd3)      dat_q   <= lslot ? 4'd0 : rd_q;
    end
  end

  assign pnl_data  = dat_q;
  assign pnl_shclk = shclk_q;
  assign pnl_latch = lslot;
  assign pnl_frame = lslot & v_last;

endmodule

// File: rtl/stn_scan_chk.sv
module stn_scan_chk #(
  parameter int WPR  = 4,
  parameter int ROWS = 4,
  parameter int HW   = 2,
  parameter int VW   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    ph,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          shclk,
  input logic          latch,
  input logic          frame,
  input logic [3:0]    data
);

  // R3
  shclk_phase_chk: assert property (@(posedge clk) disable iff (rst)
    shclk |-> (ph >= 3'd1 && ph <= 3'd4));

  // R3
  shclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shclk) |-> (ph == 3'd1 && !latch));

  // R4
  latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    latch |-> (!shclk && hcnt == HW'(WPR - 1)));

  // R4
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt <= HW'(WPR - 1));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ph != 3'd4) |-> $stable(data));

  // R6
  vcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(vcnt)) |-> ($past(latch) && !latch));

  // R6
  vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt <= VW'(ROWS - 1));

  // R7
  frame_in_latch_chk: assert property (@(posedge clk) disable iff (rst)
    frame |-> (latch && vcnt == VW'(ROWS - 1)));

endmodule

bind stn_scan stn_scan_chk #(.WPR(WPR), .ROWS(ROWS), .HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .ph(ph), .hcnt(hcnt), .vcnt(vcnt),
  .shclk(pnl_shclk), .latch(pnl_latch), .frame(pnl_frame), .data(pnl_data)
);

// File: tb/stn_scan_bench.sv
module stn_scan_bench;
  localparam int COLS = 16;
  localparam int ROWS = 4;
  localparam int WPR  = COLS / 4;
  localparam int FR   = (WPR + 1) * ROWS;
  localparam int AW   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] ha  = '0;
  logic [3:0]    hw  = '0;
  logic          hwe = 1'b0;
  logic [3:0]    hr, pd;
  logic          sc, la, fm;
  logic [3:0]    hr2, pd2;
  logic          sc2, la2, fm2;

  stn_scan #(.COLS(COLS), .ROWS(ROWS)) u_stn_scan (
    .clk(clk), .rst(rst), .hst_addr(ha), .hst_wdata(hw), .hst_we(hwe),
    .hst_rdata(hr), .pnl_data(pd), .pnl_shclk(sc), .pnl_latch(la), .pnl_frame(fm));

  stn_scan #(.COLS(8), .ROWS(2)) u_small (
    .clk(clk), .rst(rst), .hst_addr(2'd0), .hst_wdata(4'd0), .hst_we(1'b0),
    .hst_rdata(hr2), .pnl_data(pd2), .pnl_shclk(sc2), .pnl_latch(la2), .pnl_frame(fm2));

  int errs = 0;
  int checks = 0;
  bit done = 0;
  int model [WPR*ROWS];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int slot_val(input int s);
    int sf = s % FR;
    int col = sf % (WPR + 1);
    int row = sf / (WPR + 1);
    return (col == WPR) ? 0 : model[row*WPR + col];
  endfunction

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 data in reset", int'(pd), 0);
    chk("R1 shclk in reset", int'(sc), 0);
    chk("R1 latch in reset", int'(la), 0);
    chk("R1 frame in reset", int'(fm), 0);
    rst = 1'b0;
  endtask

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    ha = AW'(a); hw = 4'(d); hwe = 1'b1;
    @(negedge clk);
    hwe = 1'b0;
    model[a] = d;
  endtask

  task automatic t_host();
    host_write(5, 9);
    @(negedge clk) ha = 4'd5;
    @(negedge clk);
    chk("R2 readback", int'(hr), 9);
    hw = 4'd3; hwe = 1'b1;
    @(negedge clk);
    hwe = 1'b0;
    model[5] = 3;
    chk("R2 read during write gives old", int'(hr), 9);
    @(negedge clk);
    chk("R2 new value after write", int'(hr), 3);
  endtask

  task automatic fill(input int mul, input int add);
    for (int i = 0; i < WPR*ROWS; i++) host_write(i, (i*mul + add) & 15);
  endtask

  task automatic scan_check(input int nslots);
    for (int k = 0; k < nslots*8; k++) begin
      int s = k / 8;
      int p = k % 8;
      int sf = s % FR;
      bit lat = ((sf % (WPR + 1)) == WPR);
      bit frm = lat && (sf / (WPR + 1) == ROWS - 1);
      int ed = (p >= 4) ? slot_val(s) : ((s == 0) ? 0 : slot_val(s - 1));
      int s2 = s % 6;
      bit lat2 = ((s2 % 3) == 2);
      chk("R3 shclk", int'(sc), (!lat && p >= 1 && p <= 4) ? 1 : 0);
      chk("R4 latch", int'(la), int'(lat));
      chk("R5 data", int'(pd), ed);
      chk("R6/R7 frame", int'(fm), int'(frm));
      chk("R8 small latch", int'(la2), int'(lat2));
      chk("R8 small frame", int'(fm2), (lat2 && s2 == 5) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_midreset();
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-scan data", int'(pd), 0);
    chk("R1 mid-scan shclk", int'(sc), 0);
    chk("R1 mid-scan latch", int'(la), 0);
    do_reset();
    scan_check(FR + 3);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WPR*ROWS; i++) model[i] = 0;
    do_reset();
    t_host();
    fill(7, 3);
    do_reset();
    scan_check(2 * FR);
    fill(11, 6);
    do_reset();
    t_midreset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule